// File: doc/BRIEF.md
# Internal Oscillator Clock Switch Controller

This block picks the system clock from three internal oscillators: low, medium and high frequency. Software selects one by writing a 4-bit frequency code. The block then moves the system clock to the oscillator behind that code without producing a runt pulse. If the chosen oscillator is powered down, the block requests power for it first. It then waits out a start-up time, counted on that oscillator's own clock, or until the oscillator reports ready, whichever comes first. Only after that does it hand the clock over.

The handover runs in two halves. First the running clock is gated off on its own falling edge, so the output rests low. Then the new clock is gated on and passes its first rising edge. Only after that does the status vector move to the new oscillator. The oscillator that was left behind is then powered down. Changing to a code served by the oscillator already in use needs no start-up wait and no handover. A write that arrives during a switch is held, and it runs after the current switch ends.

Control runs on an always-on control clock `ctlClk`. Each oscillator's gate logic runs on that oscillator's clock, and every crossing between domains uses two-flop synchronizers.

Top module: `intosc_switch`

## Requirements
- R1: After reset, `oscStat` and `oscEn` both equal the one-hot mask of the source of `DEF_SEL`, `activeSel` equals `DEF_SEL`, `busy` is low, and `sysClk` runs at that source's period. No handover runs at reset.
- R2: Codes 4'b1100 to 4'b1111 select the high-frequency source; 4'b1110 is its 8 MHz tap. Codes 4'b0010 to 4'b1011 select the medium source, and 4'b0000 to 4'b0001 select the low source. In `oscEn` and `oscStat`, bit 0 is low, bit 1 is medium and bit 2 is high. `activeSel` shows the applied code once a switch completes.
- R3: A code served by the source already driving `sysClk` completes with `busy` low again within four control cycles of the write, with `oscEn` unchanged.
- R4: When the target source is powered down, its `oscEn` bit is raised. No handover begins before `STARTUP_CYC` cycles of the target clock have elapsed, unless its ready flag is set.
- R5: An asserted `oscReady` bit for the target ends the start-up wait early.
- R6: Every high pulse on `sysClk` is one complete high phase of a single source clock.
- R7: The old clock is gated off before the new one is gated on, so `sysClk` rests low across the gap. No low interval is shorter than the fastest source's low phase.
- R8: `oscStat` moves to the new source only after the new clock is driving `sysClk`. At completion, `sysClk` runs at the period of the source that `oscStat` shows.
- R9: Once a switch to a different source completes, `oscEn` is the one-hot mask of the new source, and the oscillator driving `sysClk` is always enabled.
- R10: Writes made while a switch is in progress are held, and the last one wins. It is applied after the current switch, and `busy` stays high throughout.
- R11: `busy` is high from the control cycle after a write until the last pending switch completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ctlClk | input | 1 | Always-on control clock for the select register and sequencer |
| rstN | input | 1 | Active-low asynchronous reset |
| oscClk | input | 3 | Source clocks: bit 0 low, bit 1 medium, bit 2 high frequency |
| oscReady | input | 3 | Per-source ready flags, asynchronous |
| selWr | input | 1 | Write strobe for the frequency code, sampled on `ctlClk` |
| selVal | input | 4 | Frequency code written with `selWr` |
| sysClk | output | 1 | Glitch-free system clock |
| oscEn | output | 3 | Per-source power requests |
| oscStat | output | 3 | One-hot mask of the source driving `sysClk` |
| activeSel | output | 4 | Frequency code currently applied |
| busy | output | 1 | A switch is running or a write is pending |

## Verification
The bench builds the block with `STARTUP_CYC` = 200 and `DEF_SEL` = 4'b0111, so reset leaves the medium source in charge. With 200 cycles, the start-up wait spans 800 ns on the fast source and 9200 ns on the slow one. Those windows are long enough to probe the status mid-wait. They are also far longer than the ready-flag shortcut, so the two paths are clearly told apart. The short count lets a chain of held writes and a series of random switches across all three sources finish in a few thousand control cycles.

// File: rtl/intosc_pkg.sv
package intosc_pkg;

  localparam int NSRC  = 3;
  localparam int SEL_W = 4;
  localparam int SRC_W = 2;

  typedef logic [SRC_W-1:0] srcIdx_t;

  localparam srcIdx_t SRC_LOW = 2'd0;
  localparam srcIdx_t SRC_MED = 2'd1;
  localparam srcIdx_t SRC_HIGH = 2'd2;

  // sequencer states
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WARM,
    ST_DROP,
    ST_RAISE,
    ST_STAT,
    ST_COOL
  } swState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic [NSRC-1:0] gateReq;
    logic [NSRC-1:0] powerEn;
  } swStrobe_t;

  // datapath -> control, already in the control domain
  typedef struct packed {
    logic [NSRC-1:0] gateAck;
    logic [NSRC-1:0] warmSync;
    logic [NSRC-1:0] readySync;
  } dpFeed_t;

  // map a frequency code to its oscillator
  function automatic srcIdx_t srcOf(input logic [SEL_W-1:0] code);
    if (code >= SEL_W'(12)) return SRC_HIGH;
    else if (code >= SEL_W'(2)) return SRC_MED;
    else return SRC_LOW;
  endfunction

  function automatic logic [NSRC-1:0] srcMask(input srcIdx_t idx);
    return NSRC'(1) << idx;
  endfunction

endpackage

// File: rtl/intosc_swdp.sv
module intosc_swdp
  import intosc_pkg::*;
#(
  parameter int STARTUP_CYC = 1024,
  parameter logic [SEL_W-1:0] DEF_SEL = 4'b0111
) (
  input  logic            ctlClk,
  input  logic            rstN,
  input  logic [NSRC-1:0] oscClk,
  input  logic [NSRC-1:0] oscReady,
  input  swStrobe_t       strobe,
  output dpFeed_t         feed,
  output logic            sysClk
);

  localparam srcIdx_t DEF_SRC = srcOf(DEF_SEL);
  localparam int CNT_W = $clog2(STARTUP_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_END = CNT_W'(STARTUP_CYC);

  logic [NSRC-1:0] gatedClk;
  logic [NSRC-1:0] ackV;
  logic [NSRC-1:0] warmV;
  logic [NSRC-1:0] rdyV;

  for (genvar g = 0; g < NSRC; g++) begin : gSrc
    localparam logic DEF_ON = (g == int'(DEF_SRC));

    logic reqS1, reqS2, gateBit, passAck;
    logic ackS1, ackS2;
    logic enS1, enS2, warmR;
    logic wS1, wS2, rdyS1, rdyS2;
    logic oscRstN;
    logic [CNT_W-1:0] upCnt;

    // gate request crosses into this oscillator's domain
    always_ff @(posedge oscClk[g] or negedge rstN) begin
      if (!rstN) begin
        reqS1 <= DEF_ON;
        reqS2 <= DEF_ON;
      end else begin
        reqS1 <= strobe.gateReq[g];
        reqS2 <= reqS1;
      end
    end

    // gate changes only while this clock is low
    always_ff @(negedge oscClk[g] or negedge rstN) begin
      if (!rstN) gateBit <= DEF_ON;
      else       gateBit <= reqS2;
    end

    // acknowledge once a rising edge has passed the gate
    always_ff @(posedge oscClk[g] or negedge rstN) begin
      if (!rstN) passAck <= DEF_ON;
      else       passAck <= gateBit;
    end

    always_ff @(posedge ctlClk or negedge rstN) begin
      if (!rstN) begin
        ackS1 <= DEF_ON;
        ackS2 <= DEF_ON;
      end else begin
        ackS1 <= passAck;
        ackS2 <= ackS1;
      end
    end

    // start-up counter: cleared at once when power is withdrawn
    assign oscRstN = rstN & strobe.powerEn[g];

    always_ff @(posedge oscClk[g] or negedge oscRstN) begin
      if (!oscRstN) begin
        enS1  <= 1'b0;
        enS2  <= 1'b0;
        upCnt <= '0;
        warmR <= 1'b0;
      end else begin
        enS1 <= 1'b1;
        enS2 <= enS1;
        if (enS2 && upCnt != CNT_END) upCnt <= upCnt + 1'b1;
        warmR <= enS2 && (upCnt == CNT_END);
      end
    end

    always_ff @(posedge ctlClk or negedge rstN) begin
      if (!rstN) begin
        wS1   <= 1'b0;
        wS2   <= 1'b0;
        rdyS1 <= 1'b0;
        rdyS2 <= 1'b0;
      end else begin
        wS1   <= warmR;
        wS2   <= wS1;
        rdyS1 <= oscReady[g];
        rdyS2 <= rdyS1;
      end
    end

    assign gatedClk[g] = oscClk[g] & gateBit;
    assign ackV[g]     = ackS2;
    assign warmV[g]    = wS2;
    assign rdyV[g]     = rdyS2;
  end

  assign sysClk = |gatedClk;
  assign feed = '{gateAck: ackV, warmSync: warmV, readySync: rdyV};

  // R6: at most one source is ever passing pulses to the output
  assert_single_pass_R6: assert property (@(posedge ctlClk) disable iff (!rstN)
    $countones(ackV) <= 1);

endmodule

// File: rtl/intosc_swctl.sv
module intosc_swctl
  import intosc_pkg::*;
#(
  parameter logic [SEL_W-1:0] DEF_SEL = 4'b0111
) (
  input  logic             ctlClk,
  input  logic             rstN,
  input  logic             selWr,
  input  logic [SEL_W-1:0] selVal,
  input  dpFeed_t          feed,
  output swStrobe_t        strobe,
  output logic [NSRC-1:0]  oscStat,
  output logic [SEL_W-1:0] activeSel,
  output logic             busy
);

  localparam srcIdx_t DEF_SRC = srcOf(DEF_SEL);

  swState_t         state;
  srcIdx_t          curSrc, tgtSrc, oldSrc, nxtSrc;
  logic [SEL_W-1:0] tgtSel, pendSel;
  logic             pendValid, takePend;
  logic [NSRC-1:0]  powerEn, gateReq;

  assign nxtSrc   = srcOf(pendSel);
  assign takePend = (state == ST_IDLE) && pendValid;
  assign busy     = (state != ST_IDLE) || pendValid;
  assign strobe   = '{gateReq: gateReq, powerEn: powerEn};

  always_ff @(posedge ctlClk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_IDLE;
      curSrc    <= DEF_SRC;
      tgtSrc    <= DEF_SRC;
      oldSrc    <= DEF_SRC;
      tgtSel    <= DEF_SEL;
      pendSel   <= DEF_SEL;
      pendValid <= 1'b0;
      powerEn   <= srcMask(DEF_SRC);
      gateReq   <= srcMask(DEF_SRC);
      oscStat   <= srcMask(DEF_SRC);
      activeSel <= DEF_SEL;
    end else begin
      // held write: the newest one wins
      if (selWr) begin
        pendSel   <= selVal;
        pendValid <= 1'b1;
      end else if (takePend) begin
        pendValid <= 1'b0;
      end

      case (state)
        ST_IDLE: begin
          if (pendValid) begin
            tgtSel <= pendSel;
            tgtSrc <= nxtSrc;
            if (nxtSrc == curSrc) begin
              state <= ST_STAT;
            end else begin
              powerEn <= powerEn | srcMask(nxtSrc);
              state   <= ST_WARM;
            end
          end
        end
        ST_WARM: begin
          if (feed.warmSync[tgtSrc] || feed.readySync[tgtSrc]) begin
            gateReq <= '0;
            state   <= ST_DROP;
          end
        end
        ST_DROP: begin
          if (!feed.gateAck[curSrc]) begin
            gateReq <= srcMask(tgtSrc);
            state   <= ST_RAISE;
          end
        end
        ST_RAISE: begin
          if (feed.gateAck[tgtSrc]) state <= ST_STAT;
        end
        ST_STAT: begin
          oscStat   <= srcMask(tgtSrc);
          activeSel <= tgtSel;
          if (tgtSrc != curSrc) begin
            powerEn <= srcMask(tgtSrc);
            oldSrc  <= curSrc;
            curSrc  <= tgtSrc;
            state   <= ST_COOL;
          end else begin
            state <= ST_IDLE;
          end
        end
        ST_COOL: begin
          if (!feed.warmSync[oldSrc]) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R7: never two gate requests at once
  assert_gate_req_onehot0_R7: assert property (@(posedge ctlClk) disable iff (!rstN)
    $onehot0(gateReq));

  // R8: status only moves to a source that has already passed an edge
  assert_stat_after_pass_R8: assert property (@(posedge ctlClk) disable iff (!rstN)
    (oscStat != $past(oscStat)) |-> (feed.gateAck == oscStat));

  // R4: start-up wait holds until warm or ready
  assert_warm_hold_R4: assert property (@(posedge ctlClk) disable iff (!rstN)
    (state == ST_WARM && !feed.warmSync[tgtSrc] && !feed.readySync[tgtSrc])
      |=> (state == ST_WARM));

  // R9: the driving oscillator keeps its power request
  assert_cur_powered_R9: assert property (@(posedge ctlClk) disable iff (!rstN)
    powerEn[curSrc]);

  // R11: a write makes the block busy on the next cycle
  assert_busy_after_write_R11: assert property (@(posedge ctlClk) disable iff (!rstN)
    selWr |=> busy);

endmodule

// File: rtl/intosc_switch.sv
module intosc_switch
  import intosc_pkg::*;
#(
  parameter int STARTUP_CYC = 1024,
  parameter logic [SEL_W-1:0] DEF_SEL = 4'b0111
) (
  input  logic             ctlClk,
  input  logic             rstN,
  input  logic [NSRC-1:0]  oscClk,
  input  logic [NSRC-1:0]  oscReady,
  input  logic             selWr,
  input  logic [SEL_W-1:0] selVal,
  output logic             sysClk,
  output logic [NSRC-1:0]  oscEn,
  output logic [NSRC-1:0]  oscStat,
  output logic [SEL_W-1:0] activeSel,
  output logic             busy
);

  swStrobe_t strobe;
  dpFeed_t   feed;

  intosc_swctl #(.DEF_SEL(DEF_SEL)) ctl_i (
    .ctlClk   (ctlClk),
    .rstN     (rstN),
    .selWr    (selWr),
    .selVal   (selVal),
    .feed     (feed),
    .strobe   (strobe),
    .oscStat  (oscStat),
    .activeSel(activeSel),
    .busy     (busy)
  );

  intosc_swdp #(.STARTUP_CYC(STARTUP_CYC), .DEF_SEL(DEF_SEL)) dp_i (
    .ctlClk  (ctlClk),
    .rstN    (rstN),
    .oscClk  (oscClk),
    .oscReady(oscReady),
    .strobe  (strobe),
    .feed    (feed),
    .sysClk  (sysClk)
  );

  assign oscEn = strobe.powerEn;

endmodule

// File: tb/intosc_switch_tb_top.sv
`timescale 1ns/1ps
module intosc_switch_tb_top;

  localparam int STARTUP = 200;
  localparam logic [3:0] DEFSEL = 4'b0111;

  logic       ctlClk = 1'b0;
  logic       rstN;
  logic [2:0] oscClk = 3'b000;
  logic [2:0] oscReady;
  logic       selWr;
  logic [3:0] selVal;
  logic       sysClk;
  logic [2:0] oscEn, oscStat;
  logic [3:0] activeSel;
  logic       busy;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  intosc_switch #(.STARTUP_CYC(STARTUP), .DEF_SEL(DEFSEL)) dut_i (
    .ctlClk(ctlClk), .rstN(rstN), .oscClk(oscClk), .oscReady(oscReady),
    .selWr(selWr), .selVal(selVal), .sysClk(sysClk), .oscEn(oscEn),
    .oscStat(oscStat), .activeSel(activeSel), .busy(busy)
  );

  always #5 ctlClk = ~ctlClk;
  initial begin #0.7; forever #23 oscClk[0] = ~oscClk[0]; end
  initial begin #1.3; forever #7 oscClk[1] = ~oscClk[1]; end
  initial forever #2 oscClk[2] = ~oscClk[2];

  function automatic real halfOf(input int idx);
    if (idx == 2) return 2.0;
    else if (idx == 1) return 7.0;
    else return 23.0;
  endfunction

  function automatic int expSrcOf(input logic [3:0] code);
    if (code >= 4'd12) return 2;
    else if (code >= 4'd2) return 1;
    else return 0;
  endfunction

  function automatic bit near(input real a, input real b);
    return (a - b < 0.01) && (b - a < 0.01);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // output pulse monitor
  bit  monOn = 0;
  bit  haveRise = 0, haveFall = 0;
  real tRise = 0.0, tFall = 0.0;
  int  glitchErr = 0, lowErr = 0, pulses = 0;

  always @(posedge sysClk) begin
    if (monOn && haveFall && ($realtime - tFall) < 1.99) lowErr++;
    tRise = $realtime;
    haveRise = 1;
  end

  always @(negedge sysClk) begin
    if (monOn && haveRise) begin
      if (!(near($realtime - tRise, 2.0) || near($realtime - tRise, 7.0) ||
            near($realtime - tRise, 23.0))) glitchErr++;
      pulses++;
    end
    tFall = $realtime;
    haveFall = 1;
  end

  task automatic measurePeriod(output real p);
    real t1;
    @(posedge sysClk);
    t1 = $realtime;
    @(posedge sysClk);
    p = $realtime - t1;
  endtask

  task automatic doWrite(input logic [3:0] code);
    @(negedge ctlClk);
    selWr = 1'b1;
    selVal = code;
    @(negedge ctlClk);
    selWr = 1'b0;
  endtask

  task automatic waitIdle(output int cyc);
    cyc = 0;
    while (busy && cyc < 4000) begin
      @(negedge ctlClk);
      cyc++;
    end
  endtask

  // check the state once a switch has settled
  task automatic checkSettled(input logic [3:0] code, input string tag);
    int  src;
    real p;
    src = expSrcOf(code);
    chk(busy == 1'b0, "R11", {tag, " busy after completion"}, int'(busy), 0);
    chk(activeSel == code, "R2", {tag, " activeSel"}, int'(activeSel), int'(code));
    chk(oscStat == 3'(1 << src), "R8", {tag, " oscStat"}, int'(oscStat), 1 << src);
    chk(oscEn == 3'(1 << src), "R9", {tag, " oscEn"}, int'(oscEn), 1 << src);
    measurePeriod(p);
    chk(near(p, 2.0 * halfOf(src)), "R8", {tag, " sysClk period ps"},
        int'(p * 1000.0), int'(2000.0 * halfOf(src)));
  endtask

  initial begin
    int unsigned seedInit;
    int  cyc;
    real p, t0;
    bit  dropped;
    seedInit = $urandom(32'd20240611);
    rstN = 1'b0;
    selWr = 1'b0;
    selVal = 4'd0;
    oscReady = 3'b000;
    repeat (5) @(negedge ctlClk);
    rstN = 1'b1;
    repeat (3) @(negedge ctlClk);

    // R1 reset state
    chk(oscStat == 3'b010, "R1", "oscStat after reset", int'(oscStat), 2);
    chk(oscEn == 3'b010, "R1", "oscEn after reset", int'(oscEn), 2);
    chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
    chk(activeSel == DEFSEL, "R1", "activeSel after reset", int'(activeSel), int'(DEFSEL));
    measurePeriod(p);
    chk(near(p, 14.0), "R1", "sysClk period ps after reset", int'(p * 1000.0), 14000);
    monOn = 1;

    // R3 same source: medium to medium
    doWrite(4'b0011);
    chk(busy == 1'b1, "R11", "busy after same-source write", int'(busy), 1);
    repeat (3) @(negedge ctlClk);
    chk(busy == 1'b0, "R3", "busy within four cycles", int'(busy), 0);
    chk(oscEn == 3'b010, "R3", "oscEn untouched", int'(oscEn), 2);
    checkSettled(4'b0011, "R3 same source");

    // R4 start-up wait, no ready flag, to the 8 MHz tap 1110
    doWrite(4'b1110);
    t0 = $realtime;
    @(negedge ctlClk);
    chk(oscEn == 3'b110, "R4", "target powered during wait", int'(oscEn), 6);
    #(0.9 * STARTUP * 4.0 - ($realtime - t0));
    chk(oscStat == 3'b010, "R4", "status still old mid-wait", int'(oscStat), 2);
    chk(busy == 1'b1, "R4", "busy mid-wait", int'(busy), 1);
    waitIdle(cyc);
    checkSettled(4'b1110, "R4 to high");

    // R5 ready shortcut to low
    oscReady = 3'b001;
    doWrite(4'b0000);
    waitIdle(cyc);
    chk(cyc < 100, "R5", "cycles with ready flag", cyc, 100);
    checkSettled(4'b0000, "R5 to low");
    oscReady = 3'b000;

    // R10 held writes, last wins, busy never drops
    doWrite(4'b0101);
    repeat (3) @(negedge ctlClk);
    doWrite(4'b1111);
    repeat (2) @(negedge ctlClk);
    doWrite(4'b0001);
    dropped = 0;
    cyc = 0;
    while (activeSel != 4'b0001 && cyc < 6000) begin
      @(negedge ctlClk);
      if (!busy && activeSel != 4'b0001) dropped = 1;
      cyc++;
    end
    chk(!dropped, "R10", "busy dropped before last write applied", int'(dropped), 0);
    waitIdle(cyc);
    checkSettled(4'b0001, "R10 last write");

    // random switches
    for (int i = 0; i < 16; i++) begin
      logic [3:0] code;
      int src;
      code = 4'($urandom % 16);
      src = expSrcOf(code);
      oscReady = ($urandom % 2 == 0) ? 3'(1 << src) : 3'b000;
      doWrite(code);
      chk(busy == 1'b1, "R11", "busy after random write", int'(busy), 1);
      waitIdle(cyc);
      checkSettled(code, "random");
    end

    // R6 R7 pulse shapes across every handover
    chk(glitchErr == 0, "R6", "short or odd high pulses", glitchErr, 0);
    chk(lowErr == 0, "R7", "short low intervals", lowErr, 0);
    chk(pulses > 100, "R6", "output pulses seen", pulses, 101);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    #1500000;
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule